// File: doc/BRIEF.md
# Three-Channel Triggered DMA Controller

This block copies words between memory locations without processor involvement. Three channels share one memory bus with the CPU. Each channel holds a source address, a destination address, a word count and a small set of control bits. It takes its start event from a vector of peripheral event lines through its own select field.

A channel senses its chosen event either on a rising edge or as a level. An edge requests one word. A level keeps requesting words for as long as it stays high. Each word is one read cycle followed by one write cycle. After each word the bus returns to the CPU for at least one cycle. When two or more channels request together, a programmable priority order decides which one goes first. A bus-reserve input blocks new triggers and new words, so the CPU can reprogram the block or handle urgent work. When a channel's count runs out, the channel disables itself and raises its own completion flag.

Configuration uses a single write port. The port addresses a channel and one of four registers, and a fourth channel code selects the global priority bit. Writes to a channel are ignored while that channel is enabled.

Top module: `dma3_ctrl`

## Requirements
- R1: After reset, bus_gnt_o is 1, mem_req_o is 0 and done_o is 0.
- R2: A channel reacts only to the event line evt_i[sel], where sel is control bits [11:8]. Activity on any other event line moves no word.
- R3: In edge mode (control bit 1 = 0), each rising edge of the selected event that is accepted moves exactly one word. A rising edge that arrives while an earlier edge of the same channel is still waiting for service is not counted.
- R4: In level mode (control bit 1 = 1), words keep moving while the selected event is high and the count is nonzero. No further word starts once the event is low in an idle cycle.
- R5: A word takes three steps. First comes a read cycle (mem_req_o=1, mem_we_o=0, address = source). The next cycle is a write cycle (mem_we_o=1, address = destination, mem_wdata_o = the data read). The cycle after that is idle, with bus_gnt_o=1. A pending edge seen in idle cycle t starts the read in cycle t+1.
- R6: After each word, the source address increments by one if control bit 2 is set and stays fixed otherwise. The destination address does the same under control bit 3.
- R7: Among simultaneous requests, channel 0 wins over 1, and 1 wins over 2. Writing 1 to bit 0 of the global register (channel code 3, register code 0) reverses this order. Writing 0 restores it.
- R8: While bus_hold_i is 1, rising edges are discarded, level requests are not served, and no new word starts.
- R9: bus_gnt_o is 0 exactly while a word is in progress, and mem_req_o is never 1 while bus_gnt_o is 1.
- R10: When the count of a channel reaches zero, done_o for that channel rises and the channel disables itself. An accepted write to that channel's control register clears its flag.
- R11: Writes to any register of an enabled channel (register codes: 0 control, 1 source, 2 destination, 3 count; control bit 0 = enable) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_ch_i | input | 2 | Target channel 0..2, or 3 for the global register |
| cfg_reg_i | input | 2 | Register code within the target |
| cfg_wdata_i | input | AW | Configuration write data |
| evt_i | input | NUM_EVT | Peripheral event lines |
| bus_hold_i | input | 1 | Bus reserve: blocks triggers and new words |
| bus_gnt_o | output | 1 | Bus available to the CPU |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | AW | Memory address |
| mem_wdata_o | output | DW | Memory write data |
| mem_rdata_i | input | DW | Read data, valid the cycle after a read |
| done_o | output | 3 | Per-channel completion flags |

## Verification
Arbitration and trigger capture can fall in the same cycle, because a channel's edge can arrive while a higher-priority channel holds the bus. The bench provokes this in two ways. It keeps channel 0 busy with a level request and pulses channel 1's event twice. It also fires all three channels from one shared event under both priority orders. It judges the result from the order of source addresses on the bus, and from the single word credited to the doubled edge. Randomized channel setups then compare every logged read and write against addresses and data computed from the programmed bases, the increment flags and the memory pattern.

// File: rtl/dma3_pkg.sv
package dma3_pkg;
  localparam int NUM_CH = 3;

  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} dma_st_e;

  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_SRC  = 2'd1;
  localparam logic [1:0] REG_DST  = 2'd2;
  localparam logic [1:0] REG_CNT  = 2'd3;
  localparam logic [1:0] CH_GLOBAL = 2'd3;

  localparam int CTL_EN      = 0;
  localparam int CTL_LVL     = 1;
  localparam int CTL_SINC    = 2;
  localparam int CTL_DINC    = 3;
  localparam int CTL_SEL_LSB = 8;
endpackage

// File: rtl/dma_trig.sv
module dma_trig #(
  parameter int NUM_EVT = 16,
  parameter int SEL_W   = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic               en_i,
  input  logic               level_i,
  input  logic               cnt_nz_i,
  input  logic               hold_i,
  input  logic               gnt_i,
  output logic               req_o
);
  logic sig, prev_q, pend_q, rise;

  assign sig  = (int'(sel_i) < NUM_EVT) ? evt_i[sel_i] : 1'b0;
  assign rise = sig & ~prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= sig;
      if (!en_i || gnt_i) pend_q <= 1'b0;
      else if (rise && !hold_i && !level_i) pend_q <= 1'b1;
    end
  end

  assign req_o = en_i & cnt_nz_i & (level_i ? (sig & ~hold_i) : pend_q);

  // pending edge is kept until served; extra edges fold into it (R3)
  p_edge_kept_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !level_i && pend_q && !gnt_i) |=> pend_q);

  // no edge is captured while the bus is reserved (R8)
  p_hold_no_capture_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && !pend_q) |=> !pend_q);
endmodule

// File: rtl/dma_arb.sv
module dma_arb #(
  parameter int N = 3,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  req_i,
  input  logic          rev_i,
  input  logic          start_i,
  output logic [N-1:0]  gnt_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    gnt_o = '0;
    if (start_i) begin
      if (!rev_i) begin
        for (int i = 0; i < N; i++)
          if (req_i[i] && gnt_o == '0) gnt_o[i] = 1'b1;
      end else begin
        for (int i = N - 1; i >= 0; i--)
          if (req_i[i] && gnt_o == '0) gnt_o[i] = 1'b1;
      end
    end
  end

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++)
      if (gnt_o[i]) idx_o = IW'(i);
  end

  p_onehot_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));

  p_fixed_order_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rev_i && gnt_o[N-1]) |-> (req_i[N-2:0] == '0));

  p_rev_order_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rev_i && gnt_o[0]) |-> (req_i[N-1:1] == '0));
endmodule

// File: rtl/dma_chan.sv
module dma_chan
  import dma3_pkg::*;
#(
  parameter int AW    = 16,
  parameter int SEL_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [1:0]       reg_i,
  input  logic [AW-1:0]    wdata_i,
  input  logic             step_i,
  output logic             en_o,
  output logic             level_o,
  output logic [SEL_W-1:0] sel_o,
  output logic [AW-1:0]    src_o,
  output logic [AW-1:0]    dst_o,
  output logic             cnt_nz_o,
  output logic             done_o
);
  logic [AW-1:0] cnt_q;
  logic          sinc_q, dinc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o    <= 1'b0;
      level_o <= 1'b0;
      sinc_q  <= 1'b0;
      dinc_q  <= 1'b0;
      sel_o   <= '0;
      src_o   <= '0;
      dst_o   <= '0;
      cnt_q   <= '0;
      done_o  <= 1'b0;
    end else if (we_i && !en_o) begin
      unique case (reg_i)
        REG_CTRL: begin
          en_o    <= wdata_i[CTL_EN];
          level_o <= wdata_i[CTL_LVL];
          sinc_q  <= wdata_i[CTL_SINC];
          dinc_q  <= wdata_i[CTL_DINC];
          sel_o   <= wdata_i[CTL_SEL_LSB +: SEL_W];
          done_o  <= 1'b0;
        end
        REG_SRC: src_o <= wdata_i;
        REG_DST: dst_o <= wdata_i;
        default: cnt_q <= wdata_i;
      endcase
    end else if (step_i) begin
      if (sinc_q) src_o <= src_o + 1'b1;
      if (dinc_q) dst_o <= dst_o + 1'b1;
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == AW'(1)) begin
        en_o   <= 1'b0;
        done_o <= 1'b1;
      end
    end
  end

  assign cnt_nz_o = (cnt_q != '0);

  p_cfg_locked_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_o && $past(en_o)) |-> ($stable(sel_o) && $stable(level_o)));

  p_done_disables_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> !en_o);

  p_step_live_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |-> (en_o && cnt_q != '0));
endmodule

// File: rtl/dma3_ctrl.sv
module dma3_ctrl
  import dma3_pkg::*;
#(
  parameter int AW      = 16,
  parameter int DW      = 16,
  parameter int NUM_EVT = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic [1:0]         cfg_ch_i,
  input  logic [1:0]         cfg_reg_i,
  input  logic [AW-1:0]      cfg_wdata_i,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               bus_hold_i,
  output logic               bus_gnt_o,
  output logic               mem_req_o,
  output logic               mem_we_o,
  output logic [AW-1:0]      mem_addr_o,
  output logic [DW-1:0]      mem_wdata_o,
  input  logic [DW-1:0]      mem_rdata_i,
  output logic [NUM_CH-1:0]  done_o
);
  localparam int SEL_W = $clog2(NUM_EVT);
  localparam int CH_W  = $clog2(NUM_CH);

  dma_st_e           state_q;
  logic [CH_W-1:0]   cur_q, win_idx;
  logic              prio_rev_q;
  logic [NUM_CH-1:0] req, gnt, step, en, level, cnt_nz;
  logic [SEL_W-1:0]  sel_a [NUM_CH];
  logic [AW-1:0]     src_a [NUM_CH];
  logic [AW-1:0]     dst_a [NUM_CH];
  logic              start;

  assign start = (state_q == ST_IDLE) && !bus_hold_i;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign step[g] = (state_q == ST_WR) && (cur_q == CH_W'(g));

    dma_chan #(.AW(AW), .SEL_W(SEL_W)) u_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .we_i     (cfg_we_i && cfg_ch_i == 2'(g)),
      .reg_i    (cfg_reg_i),
      .wdata_i  (cfg_wdata_i),
      .step_i   (step[g]),
      .en_o     (en[g]),
      .level_o  (level[g]),
      .sel_o    (sel_a[g]),
      .src_o    (src_a[g]),
      .dst_o    (dst_a[g]),
      .cnt_nz_o (cnt_nz[g]),
      .done_o   (done_o[g])
    );

    dma_trig #(.NUM_EVT(NUM_EVT), .SEL_W(SEL_W)) u_trig (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .evt_i    (evt_i),
      .sel_i    (sel_a[g]),
      .en_i     (en[g]),
      .level_i  (level[g]),
      .cnt_nz_i (cnt_nz[g]),
      .hold_i   (bus_hold_i),
      .gnt_i    (gnt[g]),
      .req_o    (req[g])
    );
  end

  dma_arb #(.N(NUM_CH)) u_arb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req),
    .rev_i   (prio_rev_q),
    .start_i (start),
    .gnt_o   (gnt),
    .idx_o   (win_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cur_q      <= '0;
      prio_rev_q <= 1'b0;
    end else begin
      if (cfg_we_i && cfg_ch_i == CH_GLOBAL && cfg_reg_i == REG_CTRL)
        prio_rev_q <= cfg_wdata_i[0];
      unique case (state_q)
        ST_IDLE: if (gnt != '0) begin
          state_q <= ST_RD;
          cur_q   <= win_idx;
        end
        ST_RD:   state_q <= ST_WR;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign bus_gnt_o   = (state_q == ST_IDLE);
  assign mem_req_o   = (state_q != ST_IDLE);
  assign mem_we_o    = (state_q == ST_WR);
  assign mem_addr_o  = (state_q == ST_RD) ? src_a[cur_q] : dst_a[cur_q];
  assign mem_wdata_o = mem_rdata_i;

  p_bus_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !bus_gnt_o);

  p_rd_then_wr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o) |=> (mem_req_o && mem_we_o));

  p_wr_then_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> bus_gnt_o);

  p_hold_no_start_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_hold_i && bus_gnt_o) |=> bus_gnt_o);
endmodule

// File: tb/tb_dma3_ctrl.sv
module tb_dma3_ctrl;
  localparam int AW = 16, DW = 16, NE = 16;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_ch = '0, cfg_reg = '0;
  logic [AW-1:0] cfg_wdata = '0;
  logic [NE-1:0] evt = '0;
  logic          hold = 1'b0;
  logic          bus_gnt, mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic [2:0]    done;

  int n_chk = 0, n_err = 0, conflicts = 0;
  logic [DW-1:0] mem [256];
  logic [AW-1:0] log_rd [1024], log_wr [1024];
  logic [DW-1:0] log_dat [1024];
  int log_n = 0;
  logic [AW-1:0] cur_rd;

  always #10 clk = ~clk;

  dma3_ctrl #(.AW(AW), .DW(DW), .NUM_EVT(NE)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_ch_i(cfg_ch),
    .cfg_reg_i(cfg_reg), .cfg_wdata_i(cfg_wdata), .evt_i(evt),
    .bus_hold_i(hold), .bus_gnt_o(bus_gnt), .mem_req_o(mem_req),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata), .done_o(done)
  );

  function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
    return (DW'(a[7:0]) * 16'h0101) ^ 16'h5a5a;
  endfunction

  function automatic logic [AW-1:0] ea(input logic [AW-1:0] b, input bit inc, input int k);
    return inc ? b + AW'(k) : b;
  endfunction

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = pat(AW'(i));
    mem_rdata = '0;
  end

  always @(posedge clk) begin
    if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[7:0]];
    else if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_req && bus_gnt) conflicts++;
      if (mem_req && !mem_we) cur_rd = mem_addr;
      if (mem_we && log_n < 1024) begin
        log_rd[log_n]  = cur_rd;
        log_wr[log_n]  = mem_addr;
        log_dat[log_n] = mem_wdata;
        log_n++;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] ch, input logic [1:0] rg, input logic [AW-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ch = ch; cfg_reg = rg; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic [AW-1:0] ctl(input bit en, input bit lvl, input bit si, input bit di, input int sel);
    logic [AW-1:0] v = '0;
    v[0] = en; v[1] = lvl; v[2] = si; v[3] = di; v[11:8] = 4'(sel);
    return v;
  endfunction

  task automatic prog(input int ch, input logic [AW-1:0] s, input logic [AW-1:0] d, input int cnt,
                      input bit lvl, input bit si, input bit di, input int sel);
    wr(2'(ch), 2'd1, s);
    wr(2'(ch), 2'd2, d);
    wr(2'(ch), 2'd3, AW'(cnt));
    wr(2'(ch), 2'd0, ctl(1'b1, lvl, si, di, sel));
  endtask

  task automatic pulse(input int idx);
    @(negedge clk); evt[idx] = 1'b1;
    @(negedge clk); evt[idx] = 1'b0;
  endtask

  task automatic chk_log(input int first, input int n, input logic [AW-1:0] s, input bit si,
                         input logic [AW-1:0] d, input bit di, input string tag);
    for (int k = 0; k < n; k++) begin
      chk(log_rd[first+k] == ea(s, si, k), {tag, " src addr"}, log_rd[first+k], ea(s, si, k));
      chk(log_wr[first+k] == ea(d, di, k), {tag, " dst addr"}, log_wr[first+k], ea(d, di, k));
      chk(log_dat[first+k] == pat(ea(s, si, k)), {tag, " data"}, log_dat[first+k], pat(ea(s, si, k)));
    end
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int base, cnt, ch, sel;
    bit lvl, si, di;
    logic [AW-1:0] s, d;
    void'($urandom(32'd20240611));

    tick(2);
    chk(bus_gnt == 1'b1 && mem_req == 1'b0 && done == 3'b000, "R1 reset state",
        {bus_gnt, mem_req, done}, 5'b10000);
    @(negedge clk); rst_n = 1'b1;
    tick(2);

    // R2/R5/R9: ch0 edge, sel 3, exact cycle sequence
    prog(0, 16'h10, 16'h90, 3, 1'b0, 1'b1, 1'b1, 3);
    pulse(4);
    tick(8);
    chk(log_n == 0, "R2 unselected event ignored", log_n, 0);
    @(negedge clk); evt[3] = 1'b1;
    @(negedge clk); evt[3] = 1'b0;
    chk(bus_gnt == 1'b1 && mem_req == 1'b0, "R5 pending cycle idle", {bus_gnt, mem_req}, 2'b10);
    @(negedge clk);
    chk(mem_req && !mem_we && !bus_gnt && mem_addr == 16'h10, "R5 read cycle R9",
        {mem_req, mem_we, bus_gnt, mem_addr}, {3'b100, 16'h10});
    @(negedge clk);
    chk(mem_req && mem_we && mem_addr == 16'h90 && mem_wdata == pat(16'h10), "R5 write cycle",
        {mem_we, mem_addr, mem_wdata}, {1'b1, 16'h90, pat(16'h10)});
    @(negedge clk);
    chk(bus_gnt && !mem_req, "R5 R9 bus back to cpu", {bus_gnt, mem_req}, 2'b10);
    pulse(3); tick(5); pulse(3); tick(6);
    chk(log_n == 3, "R3 one word per edge", log_n, 3);
    chk_log(0, 3, 16'h10, 1'b1, 16'h90, 1'b1, "R6 incrementing");
    chk(done[0] == 1'b1, "R10 done after count", done[0], 1);

    // R11 and R10 flag clear
    prog(0, 16'h20, 16'ha0, 2, 1'b0, 1'b1, 1'b1, 3);
    chk(done[0] == 1'b0, "R10 flag cleared by ctrl write", done[0], 0);
    wr(2'd0, 2'd1, 16'h30);
    wr(2'd0, 2'd0, ctl(1'b1, 1'b0, 1'b1, 1'b1, 4));
    base = log_n;
    pulse(4); tick(6);
    chk(log_n == base, "R11 sel write ignored while enabled", log_n - base, 0);
    pulse(3); tick(6);
    chk(log_n == base + 1 && log_rd[base] == 16'h20, "R11 src write ignored while enabled",
        log_rd[base], 16'h20);
    pulse(3); tick(6);
    chk(done[0] == 1'b1, "R10 second run done", done[0], 1);

    // R3: edges folded while ch0 level run holds the bus
    prog(0, 16'h00, 16'h80, 6, 1'b1, 1'b1, 1'b1, 1);
    prog(1, 16'h08, 16'hc0, 3, 1'b0, 1'b1, 1'b1, 2);
    base = log_n;
    @(negedge clk); evt[1] = 1'b1;
    tick(2); pulse(2); tick(1); pulse(2);
    tick(30);
    evt[1] = 1'b0;
    chk(log_n == base + 7, "R3 double edge counted once", log_n - base, 7);
    chk_log(base, 6, 16'h00, 1'b1, 16'h80, 1'b1, "R4 level run");
    chk(log_rd[base+6] == 16'h08, "R7 lower channel after higher", log_rd[base+6], 16'h08);
    pulse(2); tick(6);
    chk(log_n == base + 8 && log_rd[base+7] == 16'h09, "R3 edge after service counts",
        log_rd[base+7], 16'h09);
    pulse(2); tick(6);

    // R4 partial level run, R6 fixed source
    prog(2, 16'h30, 16'hb0, 5, 1'b1, 1'b0, 1'b1, 7);
    base = log_n;
    @(negedge clk); evt[7] = 1'b1;
    for (int w = 0; w < 40 && log_n < base + 2; w++) begin
      @(negedge clk); #1;
    end
    evt[7] = 1'b0;
    tick(10);
    chk(log_n == base + 2, "R4 stops when level drops", log_n - base, 2);
    chk(done[2] == 1'b0, "R4 no done with count left", done[2], 0);
    @(negedge clk); evt[7] = 1'b1;
    tick(15);
    evt[7] = 1'b0;
    chk(log_n == base + 5, "R4 resumes to count end", log_n - base, 5);
    chk_log(base, 5, 16'h30, 1'b0, 16'hb0, 1'b1, "R6 fixed source");
    chk(done[2] == 1'b1, "R10 ch2 done", done[2], 1);

    // R7 priority, both orders
    for (int m = 0; m < 2; m++) begin
      wr(2'd3, 2'd0, AW'(m));
      prog(0, 16'h40, 16'hd0, 1, 1'b0, 1'b1, 1'b1, 5);
      prog(1, 16'h50, 16'hd4, 1, 1'b0, 1'b1, 1'b1, 5);
      prog(2, 16'h60, 16'hd8, 1, 1'b0, 1'b1, 1'b1, 5);
      base = log_n;
      pulse(5); tick(12);
      chk(log_n == base + 3, "R7 all three served", log_n - base, 3);
      for (int k = 0; k < 3; k++) begin
        s = (m == 0) ? AW'(16'h40 + 16 * k) : AW'(16'h60 - 16 * k);
        chk(log_rd[base+k] == s, m == 0 ? "R7 fixed order" : "R7 reversed order", log_rd[base+k], s);
      end
      chk(done == 3'b111, "R10 all flags", done, 3'b111);
    end
    wr(2'd3, 2'd0, 16'h0);

    // R8 hold
    prog(0, 16'h44, 16'he0, 2, 1'b0, 1'b1, 1'b1, 6);
    base = log_n;
    @(negedge clk); hold = 1'b1;
    pulse(6); tick(4);
    @(negedge clk); hold = 1'b0;
    tick(6);
    chk(log_n == base, "R8 edge during hold discarded", log_n - base, 0);
    pulse(6); tick(6);
    chk(log_n == base + 1, "R8 edge after hold served", log_n - base, 1);
    pulse(6); tick(6);
    prog(1, 16'h48, 16'he8, 3, 1'b1, 1'b1, 1'b1, 9);
    base = log_n;
    @(negedge clk); hold = 1'b1; evt[9] = 1'b1;
    tick(20);
    chk(log_n == base && bus_gnt == 1'b1, "R8 level held off", log_n - base, 0);
    @(negedge clk); hold = 1'b0;
    tick(14);
    evt[9] = 1'b0;
    chk(log_n == base + 3, "R8 level served after hold", log_n - base, 3);

    // randomized channel runs
    for (int it = 0; it < 16; it++) begin
      ch  = int'($urandom % 3);
      sel = int'($urandom % 16);
      lvl = 1'($urandom);
      si  = 1'($urandom);
      di  = 1'($urandom);
      cnt = 1 + int'($urandom % 4);
      s   = AW'($urandom % 16'h70);
      d   = AW'(16'h80 + ($urandom % 16'h70));
      prog(ch, s, d, cnt, lvl, si, di, sel);
      base = log_n;
      if (lvl) begin
        @(negedge clk); evt[sel] = 1'b1;
        tick(3 * cnt + 6);
        evt[sel] = 1'b0;
      end else begin
        for (int p = 0; p < cnt; p++) begin
          pulse(sel); tick(4);
        end
      end
      tick(6);
      chk(log_n == base + cnt, lvl ? "R4 random word count" : "R3 random word count", log_n - base, cnt);
      chk_log(base, cnt, s, si, d, di, "R6 random");
      chk(done[ch] == 1'b1, "R10 random done", done[ch], 1);
    end

    chk(conflicts == 0, "R9 no request while cpu granted", conflicts, 0);
    summary();
    $finish;
  end
endmodule